// File: doc/BRIEF.md
# Post-Processor Control and Interrupt Register

This block is a single 32-bit control and status register that runs a video post-processing engine and produces its interrupt. Software reaches it through a plain single-cycle port: a write strobe with write data lands on the next clock edge, and the read data always shows the current register contents. The engine reports to the block through three inputs: a picture-done pulse, a bus-error pulse and the decoder's own interrupt level.

Software starts a run by setting the enable bit. The block then sends a one-cycle start pulse to the engine and holds the enable bit high until the engine reports completion or a bus error. At that point hardware clears the enable bit and raises the interrupt flag. In standalone mode it also raises the ready flag. The interrupt output is the flag gated by a disable bit, ORed with the decoder interrupt. The pipeline bit goes to the engine as a level and selects between working on the decoder's current picture and working on a separate one. No data stream passes through the block, so every pin is a plain control or status level, or a pulse.

Top module: `pp_ctrl_reg`

## Requirements
- R1: After the synchronous active-low reset, the read data is 0 and start_pulse, pipe_mode and the flag part of irq are 0.
- R2: Bit 0 is the enable bit. A write with bit 0 = 1 while enable is 0 sets enable on the next edge, and start_pulse is high for exactly that one cycle. A write with bit 0 = 1 while enable is 1 gives no pulse. Writing 0 to bit 0 has no effect.
- R3: On a picture-done pulse, hardware clears enable, sets the interrupt flag at bit 8 and, when the pipeline bit (bit 1) is 0, sets ready at bit 12. A software write in the same cycle does not override these hardware updates, and a start request in that cycle is dropped.
- R4: Bit 1 is the pipeline bit. It takes the written value and drives pipe_mode. While it is 1, ready stays 0.
- R5: Ready clears in the same cycle that start_pulse is high. Software writes to bit 12 have no effect.
- R6: Software writes bit 8. Writing 0 clears the flag and writing 1 sets it. A hardware set in the same cycle takes priority over a written 0.
- R7: Bit 4 is the interrupt disable bit. irq equals (bit 8 AND NOT bit 4) OR dec_irq, with no clock delay.
- R8: A bus-error pulse sets bit 13, sets the flag and clears enable. Writing 0 to bit 13 clears it, unless a bus-error pulse arrives in the same cycle. Writing 1 to bit 13 has no effect.
- R9: All bits other than 0, 1, 4, 8, 12 and 13 read 0, whatever is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Register write data |
| rd_data | output | 32 | Current register contents |
| pic_done | input | 1 | Engine finished a picture (one-cycle pulse) |
| bus_err | input | 1 | Engine bus error (one-cycle pulse) |
| dec_irq | input | 1 | Decoder interrupt, ORed into irq |
| start_pulse | output | 1 | One-cycle start command to the engine |
| pipe_mode | output | 1 | Pipeline mode level to the engine |
| irq | output | 1 | Combined interrupt line |

## Verification
Directed sequences test the main paths one at a time. These are: a start from idle versus a repeated set while a run is active, and completion in standalone mode versus pipeline mode, which separates the ready rule from the flag rule. They also include a bus error versus a normal completion, and a software clear landing in the same cycle as a hardware set, which checks the priority. A random phase then drives writes, done pulses, error pulses and decoder interrupts at mixed densities. A behavioural reference model is compared against every register field and output on every clock, so the masking, the reserved bits and the self-clearing bits are checked in combinations the directed part does not reach.

// File: rtl/pp_ctrl_pkg.sv
package pp_ctrl_pkg;
  localparam int REG_W    = 32;
  localparam int BIT_EN   = 0;
  localparam int BIT_PIPE = 1;
  localparam int BIT_IDIS = 4;
  localparam int BIT_FLAG = 8;
  localparam int BIT_RDY  = 12;
  localparam int BIT_BERR = 13;

  localparam logic [REG_W-1:0] LIVE_MASK =
    (REG_W'(1) << BIT_EN)   | (REG_W'(1) << BIT_PIPE) |
    (REG_W'(1) << BIT_IDIS) | (REG_W'(1) << BIT_FLAG) |
    (REG_W'(1) << BIT_RDY)  | (REG_W'(1) << BIT_BERR);

  typedef struct packed {
    logic berr;
    logic rdy;
    logic flag;
    logic idis;
    logic pipe;
    logic en;
  } pp_state_t;

  function automatic logic [REG_W-1:0] pp_pack(input pp_state_t s);
    logic [REG_W-1:0] v;
    v = '0;
    v[BIT_EN]   = s.en;
    v[BIT_PIPE] = s.pipe;
    v[BIT_IDIS] = s.idis;
    v[BIT_FLAG] = s.flag;
    v[BIT_RDY]  = s.rdy;
    v[BIT_BERR] = s.berr;
    return v;
  endfunction
endpackage

// File: rtl/pp_cfg_field.sv
module pp_cfg_field #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)     q <= '0;
    else if (wr_en) q <= d;
  end
endmodule

// File: rtl/pp_run_seq.sv
module pp_run_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic set_req,
  input  logic pic_done,
  input  logic bus_err,
  input  logic pipe_q,
  output logic en_q,
  output logic start_q,
  output logic rdy_q
);
  logic launch;

  // a run is launched only from idle and never against a hardware event
  always_comb launch = set_req & ~en_q & ~pic_done & ~bus_err;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      start_q <= 1'b0;
      rdy_q   <= 1'b0;
    end else begin
      start_q <= launch;
      if (pic_done | bus_err) en_q <= 1'b0;
      else if (launch)        en_q <= 1'b1;
      if (pic_done & ~pipe_q)   rdy_q <= 1'b1;
      else if (launch | pipe_q) rdy_q <= 1'b0;
    end
  end
endmodule

// File: rtl/pp_irq_flags.sv
module pp_irq_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic flag_wd,
  input  logic berr_wd,
  input  logic pic_done,
  input  logic bus_err,
  input  logic idis_q,
  input  logic dec_irq,
  output logic flag_q,
  output logic berr_q,
  output logic irq
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      berr_q <= 1'b0;
    end else begin
      if (pic_done | bus_err) flag_q <= 1'b1;
      else if (wr_en)         flag_q <= flag_wd;
      if (bus_err)                 berr_q <= 1'b1;
      else if (wr_en & ~berr_wd)   berr_q <= 1'b0;
    end
  end

  assign irq = (flag_q & ~idis_q) | dec_irq;
endmodule

// File: rtl/pp_ctrl_reg.sv
module pp_ctrl_reg
  import pp_ctrl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  input  logic             pic_done,
  input  logic             bus_err,
  input  logic             dec_irq,
  output logic             start_pulse,
  output logic             pipe_mode,
  output logic             irq
);
  localparam int NCFG = 2;
  localparam int CFG_POS [NCFG] = '{BIT_PIPE, BIT_IDIS};

  logic [NCFG-1:0] cfg_q;
  logic            en_q, rdy_q, flag_q, berr_q;
  logic            wd_en, wd_flag, wd_berr;
  pp_state_t       st;

  assign wd_en   = |(wr_data & (REG_W'(1) << BIT_EN));
  assign wd_flag = |(wr_data & (REG_W'(1) << BIT_FLAG));
  assign wd_berr = |(wr_data & (REG_W'(1) << BIT_BERR));

  for (genvar g = 0; g < NCFG; g++) begin : g_cfg
    pp_cfg_field #(.W(1)) u_field (
      .clk  (clk),
      .rst_n(rst_n),
      .wr_en(wr_en),
      .d    (|(wr_data & (REG_W'(1) << CFG_POS[g]))),
      .q    (cfg_q[g])
    );
  end

  pp_run_seq u_run (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_req (wr_en & wd_en),
    .pic_done(pic_done),
    .bus_err (bus_err),
    .pipe_q  (cfg_q[0]),
    .en_q    (en_q),
    .start_q (start_pulse),
    .rdy_q   (rdy_q)
  );

  pp_irq_flags u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .flag_wd (wd_flag),
    .berr_wd (wd_berr),
    .pic_done(pic_done),
    .bus_err (bus_err),
    .idis_q  (cfg_q[1]),
    .dec_irq (dec_irq),
    .flag_q  (flag_q),
    .berr_q  (berr_q),
    .irq     (irq)
  );

  always_comb begin
    st.en   = en_q;
    st.pipe = cfg_q[0];
    st.idis = cfg_q[1];
    st.flag = flag_q;
    st.rdy  = rdy_q;
    st.berr = berr_q;
  end

  assign rd_data   = pp_pack(st);
  assign pipe_mode = cfg_q[0];
endmodule

// File: rtl/pp_ctrl_reg_chk.sv
module pp_ctrl_reg_chk
  import pp_ctrl_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [REG_W-1:0] wr_data,
  input logic [REG_W-1:0] rd_data,
  input logic             pic_done,
  input logic             bus_err,
  input logic             dec_irq,
  input logic             start_pulse,
  input logic             pipe_mode,
  input logic             irq
);
  logic wd_berr;
  assign wd_berr = |(wr_data & (REG_W'(1) << BIT_BERR));

  a_r2_pulse_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |-> rd_data[BIT_EN] && !$past(rd_data[BIT_EN]));
  a_r2_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |=> !start_pulse);
  a_r3_done_stops: assert property (@(posedge clk) disable iff (!rst_n)
    pic_done |=> !rd_data[BIT_EN] && rd_data[BIT_FLAG]);
  a_r4_pipe_no_ready: assert property (@(posedge clk) disable iff (!rst_n)
    pipe_mode |=> !rd_data[BIT_RDY]);
  a_r5_ready_cleared_on_start: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |-> !rd_data[BIT_RDY]);
  a_r7_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[BIT_IDIS] && !dec_irq) |-> !irq);
  a_r7_dec_passes: assert property (@(posedge clk) disable iff (!rst_n)
    dec_irq |-> irq);
  a_r8_berr_sets: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |=> rd_data[BIT_BERR] && rd_data[BIT_FLAG] && !rd_data[BIT_EN]);
  a_r8_berr_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wd_berr && !bus_err) |=> !rd_data[BIT_BERR]);
  a_r9_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data & ~LIVE_MASK) == '0);
endmodule

bind pp_ctrl_reg pp_ctrl_reg_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
  .rd_data(rd_data), .pic_done(pic_done), .bus_err(bus_err),
  .dec_irq(dec_irq), .start_pulse(start_pulse), .pipe_mode(pipe_mode),
  .irq(irq)
);

// File: tb/pp_ctrl_reg_bench.sv
module pp_ctrl_reg_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        pic_done = 1'b0, bus_err = 1'b0, dec_irq = 1'b0;
  logic        start_pulse, pipe_mode, irq;

  int n_chk = 0;
  int n_fail = 0;
  bit go = 0;

  // reference state
  bit m_en, m_pipe, m_idis, m_flag, m_rdy, m_berr, m_start;

  always #5 clk = ~clk;

  pp_ctrl_reg u_pp_ctrl_reg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .pic_done(pic_done), .bus_err(bus_err),
    .dec_irq(dec_irq), .start_pulse(start_pulse), .pipe_mode(pipe_mode),
    .irq(irq)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural model of the register, one update per clock
  always @(posedge clk) begin
    if (!rst_n) begin
      {m_en, m_pipe, m_idis, m_flag, m_rdy, m_berr, m_start} = '0;
    end else begin
      bit hw_evt, go_run, old_pipe;
      hw_evt   = pic_done || bus_err;
      go_run   = wr_en && wr_data[0] && !m_en && !hw_evt;
      old_pipe = m_pipe;
      m_start  = go_run;
      if (hw_evt) m_en = 0; else if (go_run) m_en = 1;
      if (pic_done && !old_pipe) m_rdy = 1;
      else if (go_run || old_pipe) m_rdy = 0;
      if (hw_evt) m_flag = 1; else if (wr_en) m_flag = wr_data[8];
      if (bus_err) m_berr = 1; else if (wr_en && !wr_data[13]) m_berr = 0;
      if (wr_en) begin m_pipe = wr_data[1]; m_idis = wr_data[4]; end
    end
    go = 1;
  end

  // compare every cycle away from the edge
  always @(negedge clk) if (go) begin
    chk(rd_data[0] == m_en && start_pulse == m_start, "R2 enable/start",
        {rd_data[0], start_pulse}, {m_en, m_start});
    chk(rd_data[1] == m_pipe && pipe_mode == m_pipe, "R4 pipe", {rd_data[1], pipe_mode}, {m_pipe, m_pipe});
    chk(rd_data[4] == m_idis, "R7 disable bit", rd_data[4], m_idis);
    chk(rd_data[8] == m_flag, "R6 flag", rd_data[8], m_flag);
    chk(rd_data[12] == m_rdy, "R3 ready", rd_data[12], m_rdy);
    chk(rd_data[13] == m_berr, "R8 bus error", rd_data[13], m_berr);
    chk((rd_data & ~32'h3113) == 0, "R9 reserved", rd_data, rd_data & 32'h3113);
    chk(irq == ((m_flag && !m_idis) || dec_irq), "R7 irq", irq, (m_flag && !m_idis) || dec_irq);
  end

  task automatic cyc(input bit we, input logic [31:0] wd, input bit pd = 0, input bit be = 0, input bit di = 0);
    @(posedge clk); #1;
    wr_en = we; wr_data = wd; pic_done = pd; bus_err = be; dec_irq = di;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, '0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk(rd_data == 0 && !start_pulse && !pipe_mode && !irq, "R1 reset", rd_data, 0);

    cyc(1, 32'h1);                 // start from idle
    idle(1);
    @(negedge clk); chk(rd_data[0] == 1, "R2 run active", rd_data[0], 1);
    cyc(1, 32'h1);                 // re-set while running: no pulse
    cyc(1, 32'h0);                 // write 0 to enable: ignored
    idle(2);
    cyc(0, '0, 1);                 // picture done, standalone
    idle(1);
    @(negedge clk); chk(rd_data[12] && rd_data[8] && !rd_data[0], "R3 done", rd_data, 32'h1100);
    cyc(0, '0, 0, 0, 1);           // decoder interrupt only
    cyc(1, 32'h110);               // disable + keep flag
    cyc(0, '0, 0, 0, 1);
    cyc(1, 32'h0);                 // clear flag, enable irq
    cyc(1, 32'h1001);              // restart, bit 12 write ignored
    idle(1);
    @(negedge clk); chk(!rd_data[12], "R5 ready cleared by start", rd_data[12], 0);
    cyc(1, 32'h3);                 // pipeline mode, still running
    cyc(0, '0, 1);                 // done in pipeline mode
    idle(2);
    @(negedge clk); chk(!rd_data[12], "R4 no ready in pipeline", rd_data[12], 0);
    cyc(1, 32'h1);                 // back to standalone, start
    cyc(0, '0, 0, 1);              // bus error
    cyc(1, 32'h2101);              // write 1 to bit 13: no effect, flag kept
    cyc(1, 32'h100, 0, 1);         // clear berr races with bus error
    cyc(1, 32'h0);                 // clear berr and flag
    cyc(1, 32'h0, 1);              // flag clear races with done
    cyc(1, 32'hFFFF_FFFF);         // everything written
    cyc(1, 32'h0);
    idle(2);

    for (int i = 0; i < 600; i++) begin
      logic [31:0] r;
      r = $urandom;
      cyc(($urandom % 3) == 0, r & (i < 300 ? 32'h3113 : 32'hFFFF_FFFF),
          ($urandom % 7) == 0, ($urandom % 19) == 0, ($urandom % 5) == 0);
    end
    idle(3);
    @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule